// File: doc/BRIEF.md
# Video Line Fetch Start Controller

This block decides when one video layer asks a DMA adapter for its next line of pixels. Each request carries a block size equal to the layer's width before scaling. Once the layer is enabled, the first request goes out either at once (a prefetch) or only when the display timing's line counter reaches a programmed line. After that, each new request is triggered by a pulse that marks the last active pixel of the current line leaving the adapter FIFO. No timer is involved.

Only one request is in flight at a time. A request stays valid until the adapter acknowledges it. A trigger that arrives while a request is still waiting is kept and issued after the acknowledge. Every request is tagged with a discard flag while the controller is still in the first field or frame after starting. The downstream flow-control FIFO uses this flag to flush that data.

A sticky underrun flag reports that a line's active video began before the request for that line had been accepted. Dropping the layer enable returns the whole controller to its starting state.

Top module: `line_fetch_top`

## Requirements
- R1: After reset, `reqValid` and `underrun` are 0.
- R2: With `startFetchEn` = 0, the first clock edge that samples `layerEnable` high raises `reqValid` right after that edge.
- R3: With `startFetchEn` = 1 when the layer is enabled, no request is issued until `lineCount` equals `fetchStartLine`. `reqValid` rises right after the first edge that samples them equal.
- R4: `reqSize` equals the `layerWidth` sampled at the edge that raised `reqValid`. It stays stable while the request is outstanding, even if `layerWidth` changes.
- R5: `reqValid` stays high until an edge samples `reqAck` high, and is 0 right after that edge. At most one request is outstanding.
- R6: While running, a one-cycle `lastPixelOut` pulse issues the next request after the edge that samples it. If the pulse arrives while a request is outstanding, the new request rises one edge after the acknowledge edge.
- R7: `reqFlush` is 1 for requests issued after the start and before the first `frameStart` pulse. It is 0 for requests issued after that pulse.
- R8: While `layerEnable` is 0, the controller is idle: `reqValid` and `underrun` are 0 after the next edge, and pending triggers are dropped. On a new enable, `reqFlush` starts again at 1.
- R9: `underrun` is set after an edge that samples `activeStart` high while a request is outstanding. It then stays 1 until the layer is disabled. `activeStart` with no outstanding request leaves it at 0.
- R10: `lastPixelOut` pulses are ignored while the controller waits for the start line. They produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| layerEnable | input | 1 | Layer on; low returns the controller to idle |
| startFetchEn | input | 1 | 1: wait for start line; 0: prefetch on enable |
| fetchStartLine | input | LINE_W | Line at which fetching begins when gated |
| lineCount | input | LINE_W | Current display line from the timing generator |
| layerWidth | input | SIZE_W | Layer width before horizontal scaling |
| lastPixelOut | input | 1 | Pulse: last active pixel left the adapter FIFO |
| frameStart | input | 1 | Pulse: start of a new field or frame |
| activeStart | input | 1 | Pulse: active video of a line begins |
| reqAck | input | 1 | Adapter accepts the outstanding request |
| reqValid | output | 1 | Request outstanding |
| reqSize | output | SIZE_W | Request block size |
| reqFlush | output | 1 | Data of this request is to be discarded |
| underrun | output | 1 | Sticky: active video began before the request was accepted |

## Verification
The start of fetching is tried in two ways. An immediate prefetch tells the ungated path apart from the gated one. A line-gated start, with the counter stepped towards the threshold, shows that no request leaks out early and that stray last-pixel pulses are ignored while waiting.

Last-pixel pulses are then sent both when the adapter is idle and while a request is still unacknowledged. This separates direct issue from the queued trigger. A width change during an outstanding request distinguishes a captured size from a live one.

Requests on either side of the first frame pulse, and after a disable and re-enable, show the flush tag clearing and restarting. Active-video pulses with and without an outstanding request separate a true underrun from a false one.

// File: rtl/line_fetch_pkg.sv
package line_fetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } fetchState_t;

  typedef struct packed {
    logic issue;        // load a new request into the datapath
    logic flushTag;     // discard tag carried by the issued request
    logic clearAll;     // layer disabled: drop everything
    logic setUnderrun;  // active video began with a request outstanding
  } fetchStrobes_t;

endpackage

// File: rtl/line_fetch_ctrl.sv
module line_fetch_ctrl
  import line_fetch_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              layerEnable,
  input  logic              startFetchEn,
  input  logic [LINE_W-1:0] fetchStartLine,
  input  logic [LINE_W-1:0] lineCount,
  input  logic              lastPixelOut,
  input  logic              frameStart,
  input  logic              activeStart,
  input  logic              reqValid,
  output fetchStrobes_t     strobes
);

  fetchState_t state, nextState;
  logic pendReq, pendNext;
  logic firstFrame, flagNext;
  logic trigger, startRun, lineMatch, wantReq, issue;

  assign lineMatch = (lineCount == fetchStartLine);

  always_comb begin
    nextState = state;
    trigger   = 1'b0;
    startRun  = 1'b0;
    if (!layerEnable) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!startFetchEn || lineMatch) begin
            trigger   = 1'b1;
            startRun  = 1'b1;
            nextState = ST_RUN;
          end else begin
            nextState = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (lineMatch) begin
            trigger   = 1'b1;
            startRun  = 1'b1;
            nextState = ST_RUN;
          end
        end
        ST_RUN:  trigger = lastPixelOut;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (startRun)                          flagNext = 1'b1;
    else if (state == ST_RUN && frameStart) flagNext = 1'b0;
    else                                   flagNext = firstFrame;
  end

  assign wantReq = trigger || pendReq;
  assign issue   = layerEnable && wantReq && !reqValid;
  assign pendNext = layerEnable && wantReq && !issue;

  always_comb begin
    strobes.issue       = issue;
    strobes.flushTag    = flagNext;
    strobes.clearAll    = !layerEnable;
    strobes.setUnderrun = layerEnable && (state == ST_RUN) && activeStart && reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pendReq    <= 1'b0;
      firstFrame <= 1'b0;
    end else begin
      state      <= nextState;
      pendReq    <= pendNext;
      firstFrame <= layerEnable ? flagNext : 1'b0;
    end
  end

  // R8: disable drops state, pending trigger and first-frame tag
  assert_idle_on_disable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !layerEnable |=> (state == ST_IDLE && !pendReq && !firstFrame));

  // R3: while waiting for the start line, no request is issued before a match
  assert_wait_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && lineCount != fetchStartLine) |-> !strobes.issue);

  // R10: last-pixel pulses outside the run state leave no pending trigger
  assert_ignore_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !lineMatch && layerEnable) |=> !pendReq);

endmodule

// File: rtl/line_fetch_dp.sv
module line_fetch_dp
  import line_fetch_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobes_t     strobes,
  input  logic [SIZE_W-1:0] layerWidth,
  input  logic              reqAck,
  output logic              reqValid,
  output logic [SIZE_W-1:0] reqSize,
  output logic              reqFlush,
  output logic              underrun
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqSize  <= '0;
      reqFlush <= 1'b0;
      underrun <= 1'b0;
    end else if (strobes.clearAll) begin
      reqValid <= 1'b0;
      reqFlush <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (strobes.issue) begin
        reqValid <= 1'b1;
        reqSize  <= layerWidth;
        reqFlush <= strobes.flushTag;
      end else if (reqValid && reqAck) begin
        reqValid <= 1'b0;
      end
      if (strobes.setUnderrun) underrun <= 1'b1;
    end
  end

  // R4: size captured from the width present at the issuing edge
  assert_size_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> reqSize == $past(layerWidth));

  // R5: an unacknowledged request holds its contents
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck && !strobes.clearAll) |=> (reqValid && $stable(reqSize) && $stable(reqFlush)));

  // R5: acknowledge ends the request, no back-to-back overlap
  assert_drop_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck) |=> !reqValid);

  // R9: underrun is sticky while the layer stays enabled
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !strobes.clearAll) |=> underrun);

  // R9: underrun only rises when a request was outstanding
  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(reqValid));

endmodule

// File: rtl/line_fetch_top.sv
module line_fetch_top
  import line_fetch_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              layerEnable,
  input  logic              startFetchEn,
  input  logic [LINE_W-1:0] fetchStartLine,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [SIZE_W-1:0] layerWidth,
  input  logic              lastPixelOut,
  input  logic              frameStart,
  input  logic              activeStart,
  input  logic              reqAck,
  output logic              reqValid,
  output logic [SIZE_W-1:0] reqSize,
  output logic              reqFlush,
  output logic              underrun
);

  fetchStrobes_t strobes;

  line_fetch_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .layerEnable   (layerEnable),
    .startFetchEn  (startFetchEn),
    .fetchStartLine(fetchStartLine),
    .lineCount     (lineCount),
    .lastPixelOut  (lastPixelOut),
    .frameStart    (frameStart),
    .activeStart   (activeStart),
    .reqValid      (reqValid),
    .strobes       (strobes)
  );

  line_fetch_dp #(.SIZE_W(SIZE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .layerWidth(layerWidth),
    .reqAck    (reqAck),
    .reqValid  (reqValid),
    .reqSize   (reqSize),
    .reqFlush  (reqFlush),
    .underrun  (underrun)
  );

endmodule

// File: tb/line_fetch_top_tb.sv
`timescale 1ns/1ps
module line_fetch_top_tb;

  localparam int LINE_W = 12;
  localparam int SIZE_W = 12;

  typedef struct {
    int size;
    int flush;
  } expReq_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic layerEnable = 1'b0, startFetchEn = 1'b0;
  logic [LINE_W-1:0] fetchStartLine = '0, lineCount = '0;
  logic [SIZE_W-1:0] layerWidth = '0;
  logic lastPixelOut = 1'b0, frameStart = 1'b0, activeStart = 1'b0, reqAck = 1'b0;
  logic reqValid, reqFlush, underrun;
  logic [SIZE_W-1:0] reqSize;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expReq_t expQ[$];

  always #2.5 clk = ~clk;

  line_fetch_top #(.LINE_W(LINE_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rstN(rstN), .layerEnable(layerEnable), .startFetchEn(startFetchEn),
    .fetchStartLine(fetchStartLine), .lineCount(lineCount), .layerWidth(layerWidth),
    .lastPixelOut(lastPixelOut), .frameStart(frameStart), .activeStart(activeStart),
    .reqAck(reqAck), .reqValid(reqValid), .reqSize(reqSize), .reqFlush(reqFlush),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Acknowledge the outstanding request; returns just after the clearing edge
  task automatic doAck();
    tick();
    reqAck = 1'b1;
    tick();
    reqAck = 1'b0;
    @(negedge clk);
    check(reqValid == 1'b0, "R5 reqValid after ack", int'(reqValid), 0);
  endtask

  task automatic pulseLastPixel();
    tick();
    lastPixelOut = 1'b1;
    tick();
    lastPixelOut = 1'b0;
  endtask

  // Monitor: each accepted request is compared with the scoreboard head (R4, R7)
  always @(negedge clk) begin
    if (rstN && reqValid && reqAck) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected request", int'(reqSize), -1);
      end else begin
        expReq_t e;
        e = expQ.pop_front();
        check(int'(reqSize) == e.size, "R4 reqSize", int'(reqSize), e.size);
        check(int'(reqFlush) == e.flush, "R7 reqFlush", int'(reqFlush), e.flush);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqValid == 1'b0, "R1 reqValid in reset", int'(reqValid), 0);
    check(underrun == 1'b0, "R1 underrun in reset", int'(underrun), 0);
    tick();
    rstN = 1'b1;

    // R2: prefetch on enable
    layerWidth = 12'd100;
    startFetchEn = 1'b0;
    tick();
    layerEnable = 1'b1;
    expQ.push_back('{100, 1});
    tick();
    @(negedge clk);
    check(reqValid == 1'b1, "R2 prefetch request", int'(reqValid), 1);

    // R4/R5: width change while outstanding; request held
    tick();
    layerWidth = 12'd200;
    repeat (2) tick();
    @(negedge clk);
    check(reqValid == 1'b1, "R5 held without ack", int'(reqValid), 1);
    check(reqSize == 12'd100, "R4 size stable", int'(reqSize), 100);
    doAck();

    // R9: active video with nothing outstanding
    tick();
    activeStart = 1'b1;
    tick();
    activeStart = 1'b0;
    @(negedge clk);
    check(underrun == 1'b0, "R9 no false underrun", int'(underrun), 0);

    // R6: last pixel triggers next line, still first frame
    expQ.push_back('{200, 1});
    pulseLastPixel();
    @(negedge clk);
    check(reqValid == 1'b1, "R6 request after last pixel", int'(reqValid), 1);
    doAck();

    // R7: after frame start, flush tag clears
    tick();
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
    expQ.push_back('{200, 0});
    pulseLastPixel();
    @(negedge clk);
    check(reqValid == 1'b1, "R7 request after frame start", int'(reqValid), 1);
    doAck();

    // R6 queued trigger and R9 underrun
    expQ.push_back('{200, 0});
    pulseLastPixel();
    expQ.push_back('{200, 0});
    lastPixelOut = 1'b1;
    activeStart = 1'b1;
    tick();
    lastPixelOut = 1'b0;
    activeStart = 1'b0;
    @(negedge clk);
    check(underrun == 1'b1, "R9 underrun set", int'(underrun), 1);
    doAck();
    tick();
    @(negedge clk);
    check(reqValid == 1'b1, "R6 queued request issued", int'(reqValid), 1);
    doAck();
    check(underrun == 1'b1, "R9 underrun sticky", int'(underrun), 1);

    // R8: disable clears everything, last-pixel ignored while off
    expQ.push_back('{200, 0});
    pulseLastPixel();
    layerEnable = 1'b0;
    lastPixelOut = 1'b1;
    expQ.delete();
    tick();
    tick();
    lastPixelOut = 1'b0;
    @(negedge clk);
    check(reqValid == 1'b0, "R8 request dropped", int'(reqValid), 0);
    check(underrun == 1'b0, "R8 underrun cleared", int'(underrun), 0);

    // R3/R10: gated start at line 5
    startFetchEn = 1'b1;
    fetchStartLine = 12'd5;
    lineCount = 12'd0;
    layerWidth = 12'd64;
    layerEnable = 1'b1;
    tick();
    pulseLastPixel();
    @(negedge clk);
    check(reqValid == 1'b0, "R10 last pixel ignored while waiting", int'(reqValid), 0);
    for (int l = 1; l < 5; l++) begin
      lineCount = LINE_W'(l);
      tick();
      @(negedge clk);
      check(reqValid == 1'b0, "R3 no request before start line", int'(reqValid), 0);
    end
    lineCount = 12'd5;
    expQ.push_back('{64, 1});
    tick();
    @(negedge clk);
    check(reqValid == 1'b1, "R3 request at start line", int'(reqValid), 1);
    doAck();

    repeat (3) tick();
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule